// File: doc/BRIEF.md
# Exception Stack Frame Generator

When a processor core takes an exception, this block writes a two-longword frame to the supervisor stack. A single start strobe hands it the current supervisor stack pointer, the status register, the program counter to save, an 8-bit vector number and a 4-bit fault status. The block first rounds the stack pointer down to a longword boundary. It records the two bits it dropped in a format code from 4 to 7. It then issues two 32-bit writes over a request/acknowledge bus, with the saved program counter going first.

When both writes are finished, the block sends a one-cycle done pulse. In that cycle it also presents the stack pointer for the handler and the address of the vector table entry to fetch, which is the vector base plus four times the vector number. At the same time it raises a flag that holds off interrupt sampling. The flag drops after the core reports that it has completed its first instruction. The block does not perform the vector fetch and does not update the status register mask.

Top module: `exc_frame_gen`

## Requirements
- R1: The frame base is the start stack pointer with bits 1:0 cleared, minus 8. `newSp` equals this base from the done cycle onward, which gives the handler's stack pointer as the original value minus 8, 9, 10 or 11.
- R2: Bits 31:28 of the status longword hold the format code, which is 4 plus the value of bits 1:0 of the start stack pointer.
- R3: In the status longword, fault status bits 3:2 go to bits 27:26, the vector number goes to bits 25:18, fault status bits 1:0 go to bits 17:16, and the status register goes to bits 15:0.
- R4: The first write places the program counter at base+4. The second write places the status longword at base. Each request, along with its address and data, stays steady until `busAck` is seen, and every address is longword aligned.
- R5: `done` goes high for exactly one cycle, in the cycle after the second write is acknowledged. `newSp` and `vecAddr` change only on the edge that starts that cycle.
- R6: `vecAddr` equals `vecBase` plus the vector number times 4. Vectors 64 to 255 therefore land on offsets 0x100 to 0x3FC.
- R7: `intInhibit` goes high together with `done`. It stays high until the first `insnDone` pulse after that point and is low from the next cycle. An `insnDone` pulse while the flag is low has no effect.
- R8: `busy` is high from the cycle after an accepted start through the done cycle. A start strobe seen while `busy` is high is ignored and does not begin a new frame.
- R9: After reset, `busy`, `busReq`, `done` and `intInhibit` are low, and `newSp` and `vecAddr` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startI | input | 1 | Start strobe for a new frame |
| spIn | input | 32 | Supervisor stack pointer at the time of the exception |
| srIn | input | 16 | Status register to save |
| pcIn | input | 32 | Program counter to save |
| vecNum | input | 8 | Vector number |
| faultSt | input | 4 | Fault status |
| vecBase | input | 32 | Base address of the vector table |
| insnDone | input | 1 | Pulse when the core completes an instruction |
| busReq | output | 1 | Write request |
| busAddr | output | 32 | Write address |
| busData | output | 32 | Write data |
| busAck | input | 1 | Write acknowledge |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse when the frame is complete |
| newSp | output | 32 | Stack pointer for the handler |
| vecAddr | output | 32 | Address of the vector table entry |
| intInhibit | output | 1 | Interrupt sampling blocked |

## Verification
The sweep covers all four values of the low stack-pointer bits. This separates the rounding of the frame base from the format code, since every misalignment has to produce both a distinct code and the same aligned base. Vector numbers at 0, 63, 64 and 255, together with one-hot and all-ones fault status values, show whether any field is shifted or bit-swapped in the status longword or in the vector address. Acknowledge latencies of 0 to 2 cycles test that requests are held and that writes happen in order. A start strobe held high for the whole frame, and `insnDone` pulses sent while the flag is low, test that stimulus meant to be ignored really is ignored.

// File: rtl/exc_frame_pkg.sv
package exc_frame_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PC   = 2'd1,
    ST_FV   = 2'd2,
    ST_DONE = 2'd3
  } frameStT;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch the exception inputs
    logic selPc;    // bus carries the program counter write
    logic commit;   // publish stack pointer and vector address
  } frameCtrlT;

endpackage

// File: rtl/exc_frame_ctrl.sv
module exc_frame_ctrl
  import exc_frame_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startI,
  input  logic      busAck,
  input  logic      insnDone,
  output frameCtrlT ctrl,
  output logic      busReq,
  output logic      busy,
  output logic      done,
  output logic      intInhibit
);

  frameStT state, stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (startI) stateNext = ST_PC;
      ST_PC:   if (busAck) stateNext = ST_FV;
      ST_FV:   if (busAck) stateNext = ST_DONE;
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    ctrl.capture = (state == ST_IDLE) && startI;
    ctrl.selPc   = (state == ST_PC);
    ctrl.commit  = (state == ST_FV) && busAck;
  end

  assign busReq = (state == ST_PC) || (state == ST_FV);
  assign busy   = (state != ST_IDLE);
  assign done   = (state == ST_DONE);

  // set on the edge entering the done cycle, cleared by the first
  // completed instruction seen afterwards
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             intInhibit <= 1'b0;
    else if (ctrl.commit)  intInhibit <= 1'b1;
    else if (insnDone)     intInhibit <= 1'b0;
  end

endmodule

// File: rtl/exc_frame_dp.sv
module exc_frame_dp
  import exc_frame_pkg::*;
#(
  parameter int AW  = 32,
  parameter int VW  = 8,
  parameter int SRW = 16,
  parameter int FSW = 4
) (
  input  logic           clk,
  input  logic           rstN,
  input  frameCtrlT      ctrl,
  input  logic [AW-1:0]  spIn,
  input  logic [SRW-1:0] srIn,
  input  logic [31:0]    pcIn,
  input  logic [VW-1:0]  vecNum,
  input  logic [FSW-1:0] faultSt,
  input  logic [AW-1:0]  vecBase,
  output logic [AW-1:0]  busAddr,
  output logic [31:0]    busData,
  output logic [AW-1:0]  newSp,
  output logic [AW-1:0]  vecAddr
);

  localparam int ALIGN_BITS  = 2;
  localparam int FRAME_BYTES = 8;
  localparam int PC_OFFSET   = 4;
  localparam int VEC_SHIFT   = 2;
  localparam int FS_HALF     = FSW / 2;

  logic [AW-1:0]  baseCalc, vecCalc;
  logic [3:0]     fmtCode;
  logic [15:0]    fvWord;
  logic [AW-1:0]  baseR, vecR;
  logic [31:0]    pcR, stWordR;

  always_comb begin
    baseCalc = {spIn[AW-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}} - AW'(FRAME_BYTES);
    fmtCode  = {2'b01, spIn[ALIGN_BITS-1:0]};
    fvWord   = {fmtCode, faultSt[FSW-1:FS_HALF], vecNum, faultSt[FS_HALF-1:0]};
    vecCalc  = vecBase + (AW'(vecNum) << VEC_SHIFT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseR   <= '0;
      vecR    <= '0;
      pcR     <= '0;
      stWordR <= '0;
    end else if (ctrl.capture) begin
      baseR   <= baseCalc;
      vecR    <= vecCalc;
      pcR     <= pcIn;
      stWordR <= {fvWord, srIn};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      newSp   <= '0;
      vecAddr <= '0;
    end else if (ctrl.commit) begin
      newSp   <= baseR;
      vecAddr <= vecR;
    end
  end

  always_comb begin
    if (ctrl.selPc) begin
      busAddr = baseR + AW'(PC_OFFSET);
      busData = pcR;
    end else begin
      busAddr = baseR;
      busData = stWordR;
    end
  end

endmodule

// File: rtl/exc_frame_gen.sv
module exc_frame_gen
  import exc_frame_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startI,
  input  logic [31:0] spIn,
  input  logic [15:0] srIn,
  input  logic [31:0] pcIn,
  input  logic [7:0]  vecNum,
  input  logic [3:0]  faultSt,
  input  logic [31:0] vecBase,
  input  logic        insnDone,
  output logic        busReq,
  output logic [31:0] busAddr,
  output logic [31:0] busData,
  input  logic        busAck,
  output logic        busy,
  output logic        done,
  output logic [31:0] newSp,
  output logic [31:0] vecAddr,
  output logic        intInhibit
);

  frameCtrlT ctrl;

  exc_frame_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startI(startI), .busAck(busAck),
    .insnDone(insnDone), .ctrl(ctrl), .busReq(busReq), .busy(busy),
    .done(done), .intInhibit(intInhibit)
  );

  exc_frame_dp #(.AW(32), .VW(8), .SRW(16), .FSW(4)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .spIn(spIn), .srIn(srIn),
    .pcIn(pcIn), .vecNum(vecNum), .faultSt(faultSt), .vecBase(vecBase),
    .busAddr(busAddr), .busData(busData), .newSp(newSp), .vecAddr(vecAddr)
  );

endmodule

// File: rtl/exc_frame_chk.sv
module exc_frame_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busReq,
  input logic [31:0] busAddr,
  input logic [31:0] busData,
  input logic        busAck,
  input logic        busy,
  input logic        done,
  input logic [31:0] newSp,
  input logic [31:0] vecAddr,
  input logic        intInhibit
);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck |=> busReq && $stable(busAddr) && $stable(busData)); // R4
  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> busAddr[1:0] == 2'b00); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R5
  AST_SP_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    !done |=> $stable(newSp) || done); // R5
  AST_VEC_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    !done |=> $stable(vecAddr) || done); // R5
  AST_SP_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    done |-> newSp[1:0] == 2'b00); // R1
  AST_INHIBIT_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> intInhibit); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !busReq && !done); // R8

endmodule

bind exc_frame_gen exc_frame_chk i_chk (
  .clk(clk), .rstN(rstN), .busReq(busReq), .busAddr(busAddr),
  .busData(busData), .busAck(busAck), .busy(busy), .done(done),
  .newSp(newSp), .vecAddr(vecAddr), .intInhibit(intInhibit)
);

// File: tb/test_exc_frame_gen.sv
`timescale 1ns/1ps
module test_exc_frame_gen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startI = 1'b0;
  logic [31:0] spIn = '0;
  logic [15:0] srIn = '0;
  logic [31:0] pcIn = '0;
  logic [7:0]  vecNum = '0;
  logic [3:0]  faultSt = '0;
  logic [31:0] vecBase = '0;
  logic        insnDone = 1'b0;
  logic        busAck = 1'b0;
  logic        busReq, busy, done, intInhibit;
  logic [31:0] busAddr, busData, newSp, vecAddr;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  exc_frame_gen i_exc_frame_gen (
    .clk(clk), .rstN(rstN), .startI(startI), .spIn(spIn), .srIn(srIn),
    .pcIn(pcIn), .vecNum(vecNum), .faultSt(faultSt), .vecBase(vecBase),
    .insnDone(insnDone), .busReq(busReq), .busAddr(busAddr),
    .busData(busData), .busAck(busAck), .busy(busy), .done(done),
    .newSp(newSp), .vecAddr(vecAddr), .intInhibit(intInhibit)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic runFrame(input logic [31:0] sp, input logic [15:0] sr,
                          input logic [31:0] pc, input logic [7:0] vec,
                          input logic [3:0] fs, input int lat, input bit holdStart);
    logic [31:0] base, stWord, vAddr, oldSp, oldVec;
    base   = {sp[31:2], 2'b00} - 32'd8;
    stWord = {4'd4 + {2'b00, sp[1:0]}, fs[3:2], vec, fs[1:0], sr};
    vAddr  = vecBase + {22'd0, vec, 2'b00};
    oldSp  = newSp;
    oldVec = vecAddr;
    @(negedge clk);
    spIn = sp; srIn = sr; pcIn = pc; vecNum = vec; faultSt = fs;
    startI = 1'b1;
    @(negedge clk);
    if (!holdStart) startI = 1'b0;
    else begin
      spIn = ~sp; pcIn = ~pc; vecNum = ~vec;  // altered inputs while busy must not matter
    end
    chk("R8 busy after start", {31'd0, busy}, 32'd1);
    for (int w = 0; w < 2; w++) begin
      for (int k = 0; k < lat; k++) begin
        chk("R4 request held", {31'd0, busReq}, 32'd1);
        chk("R5 newSp unchanged", newSp, oldSp);
        @(negedge clk);
      end
      chk("R4 request", {31'd0, busReq}, 32'd1);
      if (w == 0) begin
        chk("R4 pc addr R1", busAddr, base + 32'd4);
        chk("R4 pc data", busData, pc);
      end else begin
        chk("R1 base addr", busAddr, base);
        chk("R2 R3 status longword", busData, stWord);
        chk("R5 vecAddr unchanged", vecAddr, oldVec);
      end
      busAck = 1'b1;
      @(negedge clk);
      busAck = 1'b0;
    end
    startI = 1'b0;
    chk("R5 done", {31'd0, done}, 32'd1);
    chk("R1 newSp", newSp, base);
    chk("R6 vecAddr", vecAddr, vAddr);
    chk("R7 inhibit on done", {31'd0, intInhibit}, 32'd1);
    chk("R8 busy in done", {31'd0, busy}, 32'd1);
    @(negedge clk);
    chk("R5 done width", {31'd0, done}, 32'd0);
    chk("R8 busy released", {31'd0, busy}, 32'd0);
    @(negedge clk);
    chk("R8 no restart", {31'd0, busReq}, 32'd0);
    chk("R7 inhibit held", {31'd0, intInhibit}, 32'd1);
    insnDone = 1'b1;
    @(negedge clk);
    insnDone = 1'b0;
    chk("R7 inhibit cleared", {31'd0, intInhibit}, 32'd0);
    insnDone = 1'b1;
    @(negedge clk);
    insnDone = 1'b0;
    chk("R7 insnDone ignored when clear", {31'd0, intInhibit}, 32'd0);
  endtask

  initial begin
    logic [7:0] vecs [6];
    logic [3:0] fss [4];
    vecs = '{8'd0, 8'd1, 8'd63, 8'd64, 8'd200, 8'd255};
    fss  = '{4'h1, 4'h2, 4'h4, 4'h8};
    repeat (3) @(negedge clk);
    chk("R9 busy", {31'd0, busy}, 32'd0);
    chk("R9 busReq", {31'd0, busReq}, 32'd0);
    chk("R9 done", {31'd0, done}, 32'd0);
    chk("R9 inhibit", {31'd0, intInhibit}, 32'd0);
    chk("R9 newSp", newSp, 32'd0);
    chk("R9 vecAddr", vecAddr, 32'd0);
    rstN = 1'b1;
    vecBase = 32'h0001_0000;
    for (int a = 0; a < 4; a++) begin
      for (int v = 0; v < 6; v++) begin
        runFrame(32'h2000_1000 + 32'(a) + 32'(v * 64), 16'h2700 ^ 16'(v * 37),
                 32'hC0DE_0000 + 32'(v * 6 + a), vecs[v], fss[(v + a) % 4],
                 (v + a) % 3, 1'b0);
      end
    end
    vecBase = 32'hFFFF_FF00;
    runFrame(32'h0000_0003, 16'hFFFF, 32'hFFFF_FFFF, 8'hFF, 4'hF, 0, 1'b0);
    runFrame(32'h8000_000E, 16'h0001, 32'h1234_5678, 8'd64, 4'h0, 2, 1'b1);
    runFrame(32'h0000_0009, 16'h8000, 32'h0, 8'd128, 4'hA, 1, 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule